// File: doc/BRIEF.md
# Interrupt Aggregator with Summary Status

This block gathers a small set of interrupt lines into one summary status word and turns it into a single request line for the host processor. Four lines arrive from GPIO banks, each already the OR of that bank's own pin events, and six more arrive from other peripherals. The bank lines land in the low bits of the status word and the peripheral lines in the bits just above them. Each source stays visible in the status word for as long as it holds its line high. Bank lines clear when the bank clears, and peripheral lines clear once software has serviced the source.

Software works through a 16-bit register port with three registers. The pending-status word is read-only. The enable register holds one enable bit per source, where a one lets the source through, plus a separate global enable bit. The control register carries a run bit, and the controller does nothing until that bit is set. The host request is high while the controller runs, the global enable is set and at least one enabled source is pending. Because the host senses the request on its rising edge, the line drops once every enabled source has cleared, so the next episode begins with a fresh edge.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the status word reads 0, the enable register reads 0, the control register reads 0 and `host_irq` is low.
- R2: While running, status bits 0 to 3 show bank lines 0 to 3 as they were one clock earlier, and each bit clears when its bank line clears.
- R3: While running, status bits 4 to 9 show peripheral lines 0 to 5 as they were one clock earlier, in ascending order.
- R4: Status bits 10 to 15 always read 0. Writes to the status word (address 0) change nothing.
- R5: A source can raise the request only when its enable bit (bit n of address 1, for status bit n) is 1. With every enable bit cleared, `host_irq` stays low.
- R6: Bit 15 of address 1 is the global enable. While it is 0, `host_irq` stays low whatever is pending.
- R7: Bit 0 of address 2 is the run bit. While it is 0, the status word holds 0 and `host_irq` is low. Writing 0 to address 2 stops the controller.
- R8: `host_irq` is registered. It rises two clocks after a source line rises, provided that source is enabled. It falls two clocks after the last enabled pending source clears, so each new episode produces a new rising edge.
- R9: The enable register and the control register read back what was written, in their defined bits only. Undefined bits and address 3 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bank_irq | input | 4 | Summary interrupt line of each GPIO bank |
| periph_irq | input | 6 | Level interrupt lines of the other peripherals |
| reg_addr | input | 2 | Register select: 0 status, 1 enable, 2 control |
| reg_wr | input | 1 | Write strobe, active for one clock |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected register, combinational |
| host_irq | output | 1 | Request to the host, high while an enabled source is pending |

## Verification
The inline properties hold on every cycle. They check that a stopped controller keeps an empty status word and a low request, that the status word tracks its inputs with one clock of delay, that the request never rises without the global enable or without an enabled pending source, and that the upper status bits read zero. Other behaviour shows only in the bench's scenarios. These cover the exact two-clock latency of the request, the fall and second rise that mark separate episodes, the readback of the enable and control registers, and the ignored status write. The bench also sweeps every source pattern and every enable pattern, which shows that each bit lands in its own position.

// File: rtl/irq_agg_pkg.sv
// Package: shared constants of the interrupt aggregator.
// Assumes a 16-bit register port with a 2-bit register select.
package irq_agg_pkg;
    localparam int REG_W      = 16;
    localparam int ADDR_W     = 2;
    localparam int GLOBAL_BIT = 15;
    localparam int RUN_BIT    = 0;

    typedef enum logic [ADDR_W-1:0] {
        SEL_STATUS = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/irq_agg_status.sv
// Module: captures the source lines into the pending-status word.
// Assumes the source lines are synchronous to clk. While stopped, the word is held at 0.
module irq_agg_status #(
    parameter int SRC_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SRC_W-1:0] src,
    output logic [SRC_W-1:0] status
);
    logic [SRC_W-1:0] status_q;

    // Sample the sources each clock while running; otherwise clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status_q <= '0;
        else if (run)
            status_q <= src;
        else
            status_q <= '0;
    end

    assign status = status_q;

    AST_STATUS_CLEAR_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (status == '0)); // R7

    AST_STATUS_TRACKS_SOURCES: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> (status == $past(src))); // R2
endmodule

// File: rtl/irq_agg_regs.sv
// Module: enable, global-enable and run registers plus the read multiplexer.
// Assumes that writes take effect on the strobe clock and that reads are combinational.
module irq_agg_regs
    import irq_agg_pkg::*;
#(
    parameter int SRC_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic [SRC_W-1:0]  status,
    output logic [SRC_W-1:0]  src_en,
    output logic              global_en,
    output logic              run,
    output logic [REG_W-1:0]  reg_rdata
);
    logic [SRC_W-1:0] src_en_q;
    logic             global_en_q;
    logic             run_q;
    reg_sel_e         sel;
    logic             unused_wdata;

    assign sel          = reg_sel_e'(reg_addr);
    assign unused_wdata = ^reg_wdata;

    // Load the enable register on a write to its address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_en_q    <= '0;
            global_en_q <= 1'b0;
        end else if (reg_wr && sel == SEL_ENABLE) begin
            src_en_q    <= reg_wdata[SRC_W-1:0];
            global_en_q <= reg_wdata[GLOBAL_BIT];
        end
    end

    // Load the run bit on a write to the control address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= 1'b0;
        else if (reg_wr && sel == SEL_CTRL)
            run_q <= reg_wdata[RUN_BIT];
    end

    // Select read data; undefined bits and addresses read zero.
    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            SEL_STATUS: reg_rdata[SRC_W-1:0] = status;
            SEL_ENABLE: begin
                reg_rdata[SRC_W-1:0]  = src_en_q;
                reg_rdata[GLOBAL_BIT] = global_en_q;
            end
            SEL_CTRL:   reg_rdata[RUN_BIT] = run_q;
            SEL_NONE:   reg_rdata = '0;
        endcase
    end

    assign src_en    = src_en_q;
    assign global_en = global_en_q;
    assign run       = run_q;

    AST_UPPER_STATUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_STATUS) |-> (reg_rdata[REG_W-1:SRC_W] == '0)); // R4
endmodule

// File: rtl/irq_agg_req.sv
// Module: forms the registered host request from status, enables and run.
// Assumes a host that senses the line on its rising edge.
module irq_agg_req #(
    parameter int SRC_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] status,
    input  logic [SRC_W-1:0] src_en,
    input  logic             global_en,
    input  logic             run,
    output logic             host_irq
);
    logic irq_q;

    // Raise the request when any enabled source is pending under global enable and run.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= run && global_en && (|(status & src_en));
    end

    assign host_irq = irq_q;

    AST_REQ_NEEDS_ENABLED_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & src_en) == '0) |=> !host_irq); // R5

    AST_REQ_NEEDS_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
        !global_en |=> !host_irq); // R6

    AST_REQ_LOW_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !host_irq); // R7
endmodule

// File: rtl/irq_aggregator.sv
// Module: top of the interrupt aggregator.
// Assumes banks occupy the low status bits and peripherals the bits above them.
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int NUM_BANKS  = 4,
    parameter int NUM_PERIPH = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_BANKS-1:0]  bank_irq,
    input  logic [NUM_PERIPH-1:0] periph_irq,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic                  reg_wr,
    input  logic [REG_W-1:0]      reg_wdata,
    output logic [REG_W-1:0]      reg_rdata,
    output logic                  host_irq
);
    localparam int SRC_W = NUM_BANKS + NUM_PERIPH;

    logic [SRC_W-1:0] src;
    logic [SRC_W-1:0] status;
    logic [SRC_W-1:0] src_en;
    logic             global_en;
    logic             run;

    // Place bank lines first, then peripheral lines above them.
    assign src = {periph_irq, bank_irq};

    irq_agg_status #(.SRC_W(SRC_W)) u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .src    (src),
        .status (status)
    );

    irq_agg_regs #(.SRC_W(SRC_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .status    (status),
        .src_en    (src_en),
        .global_en (global_en),
        .run       (run),
        .reg_rdata (reg_rdata)
    );

    irq_agg_req #(.SRC_W(SRC_W)) u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .status    (status),
        .src_en    (src_en),
        .global_en (global_en),
        .run       (run),
        .host_irq  (host_irq)
    );

    AST_SRC_FIT: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> ##0 (SRC_W < GLOBAL_BIT)); // R4
endmodule

// File: tb/sim_irq_aggregator.sv
`timescale 1ns/1ps
module sim_irq_aggregator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bank_irq = '0;
    logic [5:0]  periph_irq = '0;
    logic [1:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        host_irq;
    int          checks = 0;
    int          failures = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    irq_aggregator u0 (
        .clk(clk), .rst_n(rst_n), .bank_irq(bank_irq), .periph_irq(periph_irq),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .host_irq(host_irq)
    );

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic drive(input logic [9:0] s);
        bank_irq = s[3:0];
        periph_irq = s[9:4];
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        // R1: reset state
        rd(2'd0, v); chk("R1 status", v, 16'h0);
        rd(2'd1, v); chk("R1 enable", v, 16'h0);
        rd(2'd2, v); chk("R1 ctrl", v, 16'h0);
        chk("R1 irq", {15'h0, host_irq}, 16'h0);
        rst_n = 1'b1;
        drive(10'h3FF); settle();
        rd(2'd0, v); chk("R7 stopped status", v, 16'h0);
        // R9: readback of defined bits only
        wr(2'd1, 16'hFFFF); rd(2'd1, v); chk("R9 enable readback", v, 16'h83FF);
        wr(2'd1, 16'h0155); rd(2'd1, v); chk("R9 enable readback 2", v, 16'h0155);
        wr(2'd2, 16'hFFFF); rd(2'd2, v); chk("R9 ctrl readback", v, 16'h0001);
        rd(2'd3, v); chk("R9 addr3 zero", v, 16'h0);
        // R2 R3 R4: sweep all source patterns with all enabled
        wr(2'd1, 16'h83FF);
        for (int s = 0; s < 1024; s++) begin
            drive(10'(s)); settle();
            rd(2'd0, v); chk("R2 R3 R4 status position", v, 16'(s));
            chk("R8 irq level", {15'h0, host_irq}, {15'h0, s != 0});
        end
        // R4: status write ignored
        drive(10'h2A5); settle();
        wr(2'd0, 16'hFFFF); rd(2'd0, v); chk("R4 status write ignored", v, 16'h02A5);
        drive(10'h000); settle();
        wr(2'd0, 16'hFFFF); settle(); rd(2'd0, v); chk("R4 write no set", v, 16'h0);
        // R5: sweep enable patterns
        for (int m = 0; m < 1024; m++) begin
            logic [9:0] s;
            s = 10'(m * 37 + 5);
            drive(s);
            wr(2'd1, 16'h8000 | 16'(m)); settle();
            chk("R5 enable gating", {15'h0, host_irq}, {15'h0, |(s & 10'(m))});
        end
        // R6: global enable off
        drive(10'h3FF); wr(2'd1, 16'h03FF); settle();
        chk("R6 global off", {15'h0, host_irq}, 16'h0);
        // R7: run off forces low, status zero
        wr(2'd1, 16'h83FF); settle();
        chk("R7 before stop", {15'h0, host_irq}, 16'h1);
        wr(2'd2, 16'h0000); settle();
        chk("R7 stopped irq", {15'h0, host_irq}, 16'h0);
        rd(2'd0, v); chk("R7 stopped status", v, 16'h0);
        wr(2'd2, 16'h0001);
        // R8: latency and episodes
        drive(10'h000); settle();
        chk("R8 idle", {15'h0, host_irq}, 16'h0);
        for (int ep = 0; ep < 2; ep++) begin
            drive(10'h080);
            @(posedge clk); @(negedge clk);
            chk("R8 after one clock", {15'h0, host_irq}, 16'h0);
            @(posedge clk); @(negedge clk);
            chk("R8 rise two clocks", {15'h0, host_irq}, 16'h1);
            drive(10'h000);
            @(posedge clk); @(negedge clk);
            chk("R8 hold one clock", {15'h0, host_irq}, 16'h1);
            @(posedge clk); @(negedge clk);
            chk("R8 fall two clocks", {15'h0, host_irq}, 16'h0);
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                checks++; failures++;
                $display("FAIL watchdog got=hung expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule